// File: doc/BRIEF.md
# ATM Cell Receive Bus Port (PHY Side)

This block is the PHY-side sender on a byte-wide ATM cell receive bus. An upstream stream writes cells into it one byte per `up_valid` beat, with `up_sop` marking the first byte of each cell. Each 53-byte cell is stored in an internal buffer that holds `NCELLS` cells. A cell becomes readable only once all of its bytes are stored. The ATM layer drains the buffer by pulling the active-low `rd_en_n` low. For every rising edge at which `rd_en_n` is sampled low and a byte is available, the next byte appears on `bus_byte` in the following cycle. That byte comes with its odd parity bit and, on the first byte of a cell, a start-of-cell flag.

A single status pin, `bus_stat`, has two meanings, selected by `mode_cell`:
- Octet mode (`mode_cell`=0): the pin is an active-low empty indication. It is high only in cycles that carry a freshly presented byte.
- Cell mode (`mode_cell`=1): the pin is a cell-available indication. With `early_rel` set, it is withdrawn while four bytes of the last buffered cell are still to come.

A cell that arrives while every slot is occupied is discarded whole, and `drop_count` is incremented.

The write side is a three-state machine:
- WR_WAIT: idle between cells.
- WR_FILL: storing a cell. A fresh start marker restarts the cell; the 53rd byte commits it and returns the machine to WR_WAIT.
- WR_DROP: discarding a cell that found the buffer full, until the next start marker.

Transitions:
- WR_WAIT or WR_DROP go to WR_FILL on a start marker when a slot is free.
- WR_WAIT or WR_DROP go to WR_DROP on a start marker when the buffer is full.
- WR_FILL goes to WR_WAIT on the 53rd byte.

The read side has two states:
- RD_IDLE goes to RD_SEND when the enable is sampled low and a committed cell is waiting.
- RD_SEND returns to RD_IDLE after presenting byte 52.

Top module: `cellbus_rx_port`

## Requirements
- R1: No byte is presented and `bus_stat` stays low in both modes until all 53 bytes of a cell have been written; a partly written cell is invisible.
- R2: A byte is presented (registered onto `bus_byte`) in the cycle after each rising edge where `rd_en_n` was sampled low and data was available; bytes of a cell leave in write order (byte k of a cell written with value s+k reads back as s+k), and a pause in the enable resumes at the next byte.
- R3: `bus_soc` is 1 exactly in the cycle that presents byte 0 of a cell, and 0 otherwise.
- R4: `bus_par` is odd parity: the count of ones in {`bus_par`, `bus_byte`} is odd, in the same cycle as the byte.
- R5: In octet mode (`mode_cell`=0), `bus_stat` is 1 exactly in cycles carrying a newly presented byte, and 0 (empty) when the enable was high at the previous edge or nothing was buffered.
- R6: In cell mode with `early_rel`=0, `bus_stat` is 1 while a complete cell is waiting or the cell being read still has bytes left, and 0 after the last byte of the last cell is presented.
- R7: In cell mode with `early_rel`=1 and no further complete cell waiting, `bus_stat` drops to 0 as soon as only 4 bytes of the current cell remain unpresented.
- R8: The buffer holds `NCELLS` (default 4) cells; a cell whose start marker arrives while all slots are occupied is dropped whole, and `drop_count` increments by one (saturating).
- R9: A start marker in the middle of a cell being written restarts that cell from byte 0; bytes arriving outside a cell (no start marker seen) are ignored.
- R10: Cells are delivered in arrival order, and with the enable held low, byte 0 of the next waiting cell follows byte 52 of the previous one with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_valid | input | 1 | Upstream byte valid |
| up_sop | input | 1 | Upstream first byte of a cell |
| up_byte | input | 8 | Upstream data byte |
| mode_cell | input | 1 | 0 = octet (empty) status, 1 = cell-available status |
| early_rel | input | 1 | Cell mode: release cell-available 4 bytes early |
| rd_en_n | input | 1 | Active-low read enable from the ATM layer |
| bus_byte | output | 8 | Presented byte, bit 7 is the MSB |
| bus_par | output | 1 | Odd parity over `bus_byte` |
| bus_soc | output | 1 | Start-of-cell flag |
| bus_stat | output | 1 | Not-empty (octet) or cell-available (cell) |
| drop_count | output | 8 | Number of cells discarded for lack of space |

## Verification
The byte, parity and start flag belong to the enable sampled at the preceding edge. The bench drives inputs on falling edges and samples on the next falling edge, so every byte is compared exactly one clock after its enabling edge. A committed cell shows up in cell-mode status, and a dropped cell shows up in `drop_count`, in the half cycle after the edge that took the 53rd byte or the rejected start marker, and the checks are placed there. For the early-release and back-to-back cases, the bench computes the expected status for each byte index from the number of bytes still to come, so the transition cycle is checked exactly rather than approximately.

// File: rtl/cell_rx_pkg.sv
package cell_rx_pkg;
    localparam int CELL_BYTES = 53;
    localparam int EARLY_GAP  = 4;

    typedef enum logic [1:0] {
        WR_WAIT = 2'd0,
        WR_FILL = 2'd1,
        WR_DROP = 2'd2
    } wr_state_t;

    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_SEND = 1'b1
    } rd_state_t;
endpackage

// File: rtl/cell_rx_fill.sv
module cell_rx_fill
    import cell_rx_pkg::*;
#(
    parameter int NCELLS = 4,
    parameter int DW     = 8,
    parameter int CNT_W  = 8,
    localparam int AW    = $clog2(NCELLS * CELL_BYTES),
    localparam int SW    = $clog2(NCELLS),
    localparam int IW    = $clog2(CELL_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_valid,
    input  logic             up_sop,
    input  logic [DW-1:0]    up_byte,
    input  logic             full,
    output logic             wr_en,
    output logic [AW-1:0]    wr_addr,
    output logic [DW-1:0]    wr_data,
    output logic             commit,
    output logic [CNT_W-1:0] drop_count
);
    localparam logic [IW-1:0] LAST = IW'(CELL_BYTES - 1);

    wr_state_t        st, st_n;
    logic [SW-1:0]    slot_q, slot_n;
    logic [IW-1:0]    idx_q, idx_n, use_idx;
    logic             drop_hit;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st         <= WR_WAIT;
            slot_q     <= '0;
            idx_q      <= '0;
            drop_count <= '0;
        end else begin
            st     <= st_n;
            slot_q <= slot_n;
            idx_q  <= idx_n;
            if (drop_hit && (drop_count != {CNT_W{1'b1}}))
                drop_count <= drop_count + CNT_W'(1);
        end
    end

    // Next state and outputs
    always_comb begin
        st_n     = st;
        slot_n   = slot_q;
        idx_n    = idx_q;
        use_idx  = idx_q;
        wr_en    = 1'b0;
        commit   = 1'b0;
        drop_hit = 1'b0;
        unique case (st)
            WR_WAIT, WR_DROP: begin
                if (up_valid && up_sop) begin
                    if (full) begin
                        drop_hit = 1'b1;
                        st_n     = WR_DROP;
                    end else begin
                        wr_en   = 1'b1;
                        use_idx = '0;
                        idx_n   = IW'(1);
                        st_n    = WR_FILL;
                    end
                end
            end
            WR_FILL: begin
                if (up_valid) begin
                    wr_en = 1'b1;
                    if (up_sop) begin
                        use_idx = '0;
                        idx_n   = IW'(1);
                    end else if (idx_q == LAST) begin
                        idx_n  = '0;
                        commit = 1'b1;
                        slot_n = slot_q + SW'(1);
                        st_n   = WR_WAIT;
                    end else begin
                        idx_n = idx_q + IW'(1);
                    end
                end
            end
            default: st_n = WR_WAIT;
        endcase
    end

    assign wr_addr = AW'(slot_q) * AW'(CELL_BYTES) + AW'(use_idx);
    assign wr_data = up_byte;

    AST_COMMIT_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !full); // R8
    AST_DROP_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
        (st != WR_FILL && up_valid && up_sop && full && drop_count != {CNT_W{1'b1}})
        |=> (drop_count == $past(drop_count) + CNT_W'(1))); // R8
    AST_NO_WRITE_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (st != WR_FILL && !up_sop) |-> !wr_en); // R9
endmodule

// File: rtl/cell_rx_store.sv
module cell_rx_store #(
    parameter int DEPTH = 212,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rdata <= '0;
        else if (re)
            rdata <= mem[raddr];
    end
endmodule

// File: rtl/cell_rx_drain.sv
module cell_rx_drain
    import cell_rx_pkg::*;
#(
    parameter int NCELLS = 4,
    localparam int AW    = $clog2(NCELLS * CELL_BYTES),
    localparam int SW    = $clog2(NCELLS),
    localparam int IW    = $clog2(CELL_BYTES),
    localparam int CW    = $clog2(NCELLS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en_n,
    input  logic          commit,
    input  logic          mode_cell,
    input  logic          early_rel,
    output logic          re,
    output logic [AW-1:0] raddr,
    output logic          vld,
    output logic          soc,
    output logic          stat,
    output logic          full
);
    localparam logic [IW-1:0] LAST   = IW'(CELL_BYTES - 1);
    localparam logic [IW-1:0] REL_AT = IW'(CELL_BYTES - EARLY_GAP);

    rd_state_t      st, st_n;
    logic [SW-1:0]  slot_q, slot_n;
    logic [IW-1:0]  idx_q, idx_n, use_idx;
    logic [CW-1:0]  ready_q, used;
    logic           take;
    logic           clav;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= RD_IDLE;
            slot_q  <= '0;
            idx_q   <= '0;
            ready_q <= '0;
            vld     <= 1'b0;
            soc     <= 1'b0;
        end else begin
            st      <= st_n;
            slot_q  <= slot_n;
            idx_q   <= idx_n;
            ready_q <= ready_q + CW'(commit) - CW'(take);
            vld     <= re;
            soc     <= take;
        end
    end

    // Next state and outputs
    always_comb begin
        st_n    = st;
        slot_n  = slot_q;
        idx_n   = idx_q;
        use_idx = idx_q;
        re      = 1'b0;
        take    = 1'b0;
        unique case (st)
            RD_IDLE: begin
                if (!rd_en_n && ready_q != '0) begin
                    re      = 1'b1;
                    take    = 1'b1;
                    use_idx = '0;
                    idx_n   = IW'(1);
                    st_n    = RD_SEND;
                end
            end
            RD_SEND: begin
                if (!rd_en_n) begin
                    re = 1'b1;
                    if (idx_q == LAST) begin
                        idx_n  = '0;
                        slot_n = slot_q + SW'(1);
                        st_n   = RD_IDLE;
                    end else begin
                        idx_n = idx_q + IW'(1);
                    end
                end
            end
            default: st_n = RD_IDLE;
        endcase
    end

    assign raddr = AW'(slot_q) * AW'(CELL_BYTES) + AW'(use_idx);
    assign used  = ready_q + CW'(st == RD_SEND);
    assign full  = (used >= CW'(NCELLS));
    assign clav  = (ready_q != '0) ||
                   ((st == RD_SEND) && (!early_rel || (idx_q < REL_AT)));
    assign stat  = mode_cell ? clav : vld;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        used <= CW'(NCELLS)); // R8
    AST_NO_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RD_IDLE && ready_q == '0) |=> !vld); // R1
    AST_BYTE_AFTER_EN: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> $past(!rd_en_n)); // R2
    AST_SOC_STARTS_CELL: assert property (@(posedge clk) disable iff (!rst_n)
        soc |-> (vld && st == RD_SEND && idx_q == IW'(1))); // R3
    AST_EARLY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_cell && early_rel && ready_q == '0 && st == RD_SEND && idx_q >= REL_AT)
        |-> !stat); // R7
    AST_CELL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_cell && !early_rel && st == RD_SEND) |-> stat); // R6
endmodule

// File: rtl/cellbus_rx_port.sv
module cellbus_rx_port
    import cell_rx_pkg::*;
#(
    parameter int NCELLS = 4,
    parameter int CNT_W  = 8,
    localparam int DW    = 8,
    localparam int DEPTH = NCELLS * CELL_BYTES,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_valid,
    input  logic             up_sop,
    input  logic [DW-1:0]    up_byte,
    input  logic             mode_cell,
    input  logic             early_rel,
    input  logic             rd_en_n,
    output logic [DW-1:0]    bus_byte,
    output logic             bus_par,
    output logic             bus_soc,
    output logic             bus_stat,
    output logic [CNT_W-1:0] drop_count
);
    logic          full, commit, we, re;
    logic [AW-1:0] waddr, raddr;
    logic [DW-1:0] wdata, rdata;

    cell_rx_fill #(.NCELLS(NCELLS), .DW(DW), .CNT_W(CNT_W)) u_fill (
        .clk(clk), .rst_n(rst_n),
        .up_valid(up_valid), .up_sop(up_sop), .up_byte(up_byte),
        .full(full), .wr_en(we), .wr_addr(waddr), .wr_data(wdata),
        .commit(commit), .drop_count(drop_count)
    );

    cell_rx_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n),
        .we(we), .waddr(waddr), .wdata(wdata),
        .re(re), .raddr(raddr), .rdata(rdata)
    );

    cell_rx_drain #(.NCELLS(NCELLS)) u_drain (
        .clk(clk), .rst_n(rst_n),
        .rd_en_n(rd_en_n), .commit(commit),
        .mode_cell(mode_cell), .early_rel(early_rel),
        .re(re), .raddr(raddr),
        .vld(), .soc(bus_soc), .stat(bus_stat), .full(full)
    );

    assign bus_byte = rdata;
    assign bus_par  = ~^rdata;

    AST_ODD_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones({bus_par, bus_byte}) % 2) == 1); // R4
endmodule

// File: tb/cellbus_rx_port_tb.sv
module cellbus_rx_port_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       up_valid = 1'b0, up_sop = 1'b0;
    logic [7:0] up_byte = '0;
    logic       mode_cell = 1'b0, early_rel = 1'b0;
    logic       rd_en_n = 1'b1;
    logic [7:0] bus_byte;
    logic       bus_par, bus_soc, bus_stat;
    logic [7:0] drop_count;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cellbus_rx_port u_dut (
        .clk(clk), .rst_n(rst_n),
        .up_valid(up_valid), .up_sop(up_sop), .up_byte(up_byte),
        .mode_cell(mode_cell), .early_rel(early_rel), .rd_en_n(rd_en_n),
        .bus_byte(bus_byte), .bus_par(bus_par), .bus_soc(bus_soc),
        .bus_stat(bus_stat), .drop_count(drop_count)
    );

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Feed n bytes seed+i; start marker on the first one if with_sop
    task automatic push_bytes(int seed, int n, bit with_sop);
        for (int i = 0; i < n; i++) begin
            up_valid = 1'b1;
            up_sop   = with_sop && (i == 0);
            up_byte  = 8'(seed + i);
            @(negedge clk);
        end
        up_valid = 1'b0;
        up_sop   = 1'b0;
    endtask

    // Read count bytes starting at index first of cell seed
    task automatic read_seg(string req, int seed, int first, int count, bit more_q, bit keep);
        rd_en_n = 1'b0;
        for (int i = 0; i < count; i++) begin
            int idx;
            logic [7:0] b;
            int exp_stat;
            @(negedge clk);
            idx = first + i;
            b   = 8'(seed + idx);
            if (mode_cell)
                exp_stat = int'(more_q || (idx < 52 && (!early_rel || idx < 48)));
            else
                exp_stat = 1;
            chk(req, "byte (R2)", int'(bus_byte), int'(b));
            chk(req, "soc (R3)", int'(bus_soc), int'(idx == 0));
            chk(req, "odd parity (R4)", ($countones({bus_par, bus_byte}) % 2), 1);
            chk(req, "status", int'(bus_stat), exp_stat);
        end
        if (!keep) rd_en_n = 1'b1;
    endtask

    task automatic check_empty(string req, int n);
        rd_en_n = 1'b0;
        repeat (n) begin
            @(negedge clk);
            chk(req, "status empty", int'(bus_stat), 0);
            chk(req, "soc idle", int'(bus_soc), 0);
        end
        rd_en_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R5", "reset status", int'(bus_stat), 0);
        chk("R3", "reset soc", int'(bus_soc), 0);
        chk("R8", "reset drop_count", int'(drop_count), 0);
    endtask

    task automatic t_partial_restart();
        push_bytes(5, 30, 1'b1);
        mode_cell = 1'b1;
        @(negedge clk);
        chk("R1", "cell-mode status with partial cell", int'(bus_stat), 0);
        mode_cell = 1'b0;
        check_empty("R1", 3);
        push_bytes(70, 53, 1'b1);
        read_seg("R9", 70, 0, 53, 1'b0, 1'b0);
        push_bytes(200, 5, 1'b0);
        check_empty("R9", 2);
    endtask

    task automatic t_octet_pause();
        push_bytes(80, 53, 1'b1);
        read_seg("R2", 80, 0, 10, 1'b0, 1'b0);
        repeat (3) begin
            @(negedge clk);
            chk("R5", "status while enable high", int'(bus_stat), 0);
            chk("R3", "soc while paused", int'(bus_soc), 0);
        end
        read_seg("R2", 80, 10, 43, 1'b0, 1'b0);
        check_empty("R5", 2);
    endtask

    task automatic t_cell_plain();
        mode_cell = 1'b1;
        early_rel = 1'b0;
        @(negedge clk);
        chk("R6", "clav with empty buffer", int'(bus_stat), 0);
        push_bytes(90, 53, 1'b1);
        chk("R6", "clav after commit", int'(bus_stat), 1);
        read_seg("R6", 90, 0, 53, 1'b0, 1'b0);
        @(negedge clk);
        chk("R6", "clav after drain", int'(bus_stat), 0);
    endtask

    task automatic t_cell_early();
        mode_cell = 1'b1;
        early_rel = 1'b1;
        push_bytes(100, 53, 1'b1);
        chk("R7", "clav before read", int'(bus_stat), 1);
        read_seg("R7", 100, 0, 53, 1'b0, 1'b0);
        @(negedge clk);
    endtask

    task automatic t_back_to_back();
        mode_cell = 1'b1;
        early_rel = 1'b1;
        push_bytes(110, 53, 1'b1);
        push_bytes(120, 53, 1'b1);
        read_seg("R10", 110, 0, 53, 1'b1, 1'b1);
        read_seg("R10", 120, 0, 53, 1'b0, 1'b0);
        @(negedge clk);
        chk("R10", "clav after both cells", int'(bus_stat), 0);
    endtask

    task automatic t_overflow();
        mode_cell = 1'b0;
        early_rel = 1'b0;
        push_bytes(10, 53, 1'b1);
        push_bytes(20, 53, 1'b1);
        push_bytes(30, 53, 1'b1);
        push_bytes(40, 53, 1'b1);
        chk("R8", "no drop while room", int'(drop_count), 0);
        push_bytes(50, 53, 1'b1);
        chk("R8", "drop_count after full", int'(drop_count), 1);
        read_seg("R8", 10, 0, 53, 1'b0, 1'b1);
        read_seg("R8", 20, 0, 53, 1'b0, 1'b1);
        read_seg("R8", 30, 0, 53, 1'b0, 1'b1);
        read_seg("R8", 40, 0, 53, 1'b0, 1'b0);
        check_empty("R8", 3);
        chk("R8", "drop_count stable", int'(drop_count), 1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_partial_restart();
        t_octet_pause();
        t_cell_plain();
        t_cell_early();
        t_back_to_back();
        t_overflow();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule